// File: doc/BRIEF.md
# Banked System Control Register File

This block holds the privileged system-control registers that a processor core reaches through its coprocessor register-transfer path. Each access names a 4-bit register number together with three qualifiers: a 3-bit primary opcode, a 3-bit secondary opcode and a 4-bit auxiliary register field. The block checks the combination against a per-register legality table and either accepts the access or refuses it. Accepted writes pass through a per-register mask that keeps some bits, forces others to zero and, for the control register, forces a group to one.

Storage is split into two banks of sixteen 32-bit words. The primary bank is used when the secondary opcode is zero and the alternate bank when it is nonzero. Register 14 is special: it holds five breakpoint-related words chosen by the auxiliary field. The operation registers (7, 8 and 10) trigger external actions, so their writes are accepted but store nothing. When a control-register write flips the byte-order bit, the block emits a one-cycle change pulse and drives the new byte-order level.

The response comes back one cycle after the request. A small response state machine has four states: `RSP_IDLE` (no response), `RSP_READ` (accepted read, data valid), `RSP_WRITE` (accepted write) and `RSP_REFUSE` (refused access, data zero). Each cycle the machine moves to `RSP_REFUSE` on an illegal request, to `RSP_READ` or `RSP_WRITE` on a legal one, and to `RSP_IDLE` when no request is presented.

Top module: `sysctl_regfile`

## Requirements
- R1: An access made with `req_user` high is refused; a refused write leaves all state unchanged.
- R2: An access whose primary opcode (`req_op1`) is nonzero is refused and changes no state.
- R3: Every request gets exactly one response in the next cycle (`rsp_valid` high); with no request `rsp_valid` is low; a refused access returns `rsp_rdata` = 0 and leaves stored values unchanged.
- R4: After reset, primary register 0 reads 0x69052000, primary register 1 reads 0x00000078, alternate register 0 reads 0x0B1AA1AA, every other register reads 0, and `endian_level` is 0.
- R5: `req_op2` = 0 selects the primary bank and a nonzero `req_op2` selects the alternate bank, so register 1 holds the control word and the auxiliary-control word independently.
- R6: Register 0 in both banks is read-only: a write is accepted but the value read back is unchanged.
- R7: A write to primary register 1 stores the written bits 13:11, 9:7 and 2:0, forces bits 31:14 and 10 to 0 and bits 6:3 to 1.
- R8: A control-register write that changes bit 7 raises `endian_pulse` for exactly the response cycle and `endian_level` then equals the new bit 7; `endian_level` never changes without the pulse.
- R9: Write masks: register 2 keeps bits 31:14, register 5 keeps 10:9 and 7:0, register 13 keeps 31:25, register 9 keeps bit 0, and alternate register 1 keeps bits 5:4 and 1:0.
- R10: Register 15 is legal only with `req_crm` = 1 and `req_op2` = 0, and only bits 13:0 are writable.
- R11: Register 14 requires `req_op2` = 0 and `req_crm` of 0, 3, 4, 8 or 9; each of these five values selects its own fully writable word, and any other value is refused.
- R12: Registers 2, 3, 5, 6 and 13 need `req_crm` = 0 and `req_op2` = 0; registers 4, 11 and 12 are always refused; registers 0 and 1 need `req_crm` = 0 with `req_op2` of any value for 0 and of 0 or 1 for 1.
- R13: Register 7 is legal for (`req_op2`,`req_crm`) pairs (0,5..7), (1,5/6/10), (4,10), (5,2), (6,5); register 8 for `req_crm` 5..7 with `req_op2` 0 or 1 except (1,7); register 9 for `req_crm` 0/1 with `req_op2` 1/2; register 10 for `req_crm` 0/1 with `req_op2` 4. Registers 7, 8 and 10 accept writes, store nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Requester is in unprivileged mode |
| req_reg | input | 4 | Register number |
| req_op1 | input | 3 | Primary opcode qualifier |
| req_op2 | input | 3 | Secondary opcode qualifier, bank select |
| req_crm | input | 4 | Auxiliary register field |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_refused | output | 1 | The access was refused |
| rsp_rdata | output | 32 | Read data, zero unless an accepted read |
| endian_pulse | output | 1 | One-cycle pulse on a byte-order change |
| endian_level | output | 1 | Current byte-order bit of the control word |

## Verification
The main stimulus walks every register number across legal and illegal qualifier pairs, writing all-ones so that a read-back shows each mask bit by bit and tells a missing force-to-one or force-to-zero apart from a wrong keep field. Reads of the same register number with zero and nonzero secondary opcode tell a missing bank split apart from a shared word. Refused writes from user mode and with a nonzero primary opcode are each followed by a read of the target register, which tells a true refusal apart from a refusal that still stores. Three control writes in a row (bit 7 flips, stays, flips back) tell a level-change pulse apart from one raised on every write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_W     = 4;
    localparam int OP_W      = 3;
    localparam int CRM_W     = 4;
    localparam int NUM_REGS  = 1 << REG_W;
    localparam int NUM_BP    = 5;
    localparam int BP_IDX_W  = $clog2(NUM_BP);

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_READ   = 2'd1,
        RSP_WRITE  = 2'd2,
        RSP_REFUSE = 2'd3
    } rsp_state_t;

    localparam logic [REG_W-1:0] RN_IDENT  = 4'd0;
    localparam logic [REG_W-1:0] RN_CTRL   = 4'd1;
    localparam logic [REG_W-1:0] RN_XLAT   = 4'd2;
    localparam logic [REG_W-1:0] RN_DOMAIN = 4'd3;
    localparam logic [REG_W-1:0] RN_FSTAT  = 4'd5;
    localparam logic [REG_W-1:0] RN_FADDR  = 4'd6;
    localparam logic [REG_W-1:0] RN_CACHEOP= 4'd7;
    localparam logic [REG_W-1:0] RN_TLBOP  = 4'd8;
    localparam logic [REG_W-1:0] RN_DLOCK  = 4'd9;
    localparam logic [REG_W-1:0] RN_TLBLCK = 4'd10;
    localparam logic [REG_W-1:0] RN_PID    = 4'd13;
    localparam logic [REG_W-1:0] RN_BRKPT  = 4'd14;
    localparam logic [REG_W-1:0] RN_CPACC  = 4'd15;

    localparam logic [DATA_W-1:0] RST_IDENT  = 32'h6905_2000;
    localparam logic [DATA_W-1:0] RST_CTRL   = 32'h0000_0078;
    localparam logic [DATA_W-1:0] RST_CTYPE  = 32'h0B1A_A1AA;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_3B87;
    localparam logic [DATA_W-1:0] CTRL_SET   = 32'h0000_0078;
    localparam int                CTRL_ENDIAN_BIT = 7;
    localparam logic [DATA_W-1:0] XLAT_KEEP  = 32'hFFFF_C000;
    localparam logic [DATA_W-1:0] FSTAT_KEEP = 32'h0000_06FF;
    localparam logic [DATA_W-1:0] PID_KEEP   = 32'hFE00_0000;
    localparam logic [DATA_W-1:0] DLOCK_KEEP = 32'h0000_0001;
    localparam logic [DATA_W-1:0] AUX_KEEP   = 32'h0000_0033;
    localparam logic [DATA_W-1:0] CPACC_KEEP = 32'h0000_3FFF;

    // Maps the auxiliary field of a register-14 access onto a breakpoint slot.
    function automatic logic [BP_IDX_W-1:0] bp_slot(input logic [CRM_W-1:0] crm);
        unique case (crm)
            4'd3:    bp_slot = BP_IDX_W'(1);
            4'd4:    bp_slot = BP_IDX_W'(2);
            4'd8:    bp_slot = BP_IDX_W'(3);
            4'd9:    bp_slot = BP_IDX_W'(4);
            default: bp_slot = BP_IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/sysctl_legal.sv
module sysctl_legal
    import sysctl_pkg::*;
(
    input  logic             user_mode,
    input  logic [REG_W-1:0] reg_num,
    input  logic [OP_W-1:0]  op1,
    input  logic [OP_W-1:0]  op2,
    input  logic [CRM_W-1:0] crm,
    output logic             legal
);

    logic per_reg_ok;

    always_comb begin
        per_reg_ok = 1'b0;
        unique case (reg_num)
            RN_IDENT:  per_reg_ok = (crm == 4'd0);
            RN_CTRL:   per_reg_ok = (crm == 4'd0) && (op2 <= 3'd1);
            RN_XLAT, RN_DOMAIN, RN_FSTAT, RN_FADDR, RN_PID:
                       per_reg_ok = (crm == 4'd0) && (op2 == 3'd0);
            RN_CACHEOP: begin
                unique case (op2)
                    3'd0:    per_reg_ok = (crm >= 4'd5) && (crm <= 4'd7);
                    3'd1:    per_reg_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                    3'd4:    per_reg_ok = (crm == 4'd10);
                    3'd5:    per_reg_ok = (crm == 4'd2);
                    3'd6:    per_reg_ok = (crm == 4'd5);
                    default: per_reg_ok = 1'b0;
                endcase
            end
            RN_TLBOP:  per_reg_ok = (crm >= 4'd5) && (crm <= 4'd7) && (op2 <= 3'd1)
                                    && !((op2 == 3'd1) && (crm == 4'd7));
            RN_DLOCK:  per_reg_ok = (crm <= 4'd1) && ((op2 == 3'd1) || (op2 == 3'd2));
            RN_TLBLCK: per_reg_ok = (crm <= 4'd1) && (op2 == 3'd4);
            RN_BRKPT:  per_reg_ok = (op2 == 3'd0) &&
                                    ((crm == 4'd0) || (crm == 4'd3) || (crm == 4'd4) ||
                                     (crm == 4'd8) || (crm == 4'd9));
            RN_CPACC:  per_reg_ok = (crm == 4'd1) && (op2 == 3'd0);
            default:   per_reg_ok = 1'b0;
        endcase
    end

    assign legal = !user_mode && (op1 == '0) && per_reg_ok;

endmodule

// File: rtl/sysctl_wmask.sv
module sysctl_wmask
    import sysctl_pkg::*;
(
    input  logic [REG_W-1:0]  reg_num,
    input  logic              alt_bank,
    input  logic [DATA_W-1:0] wdata,
    output logic              store,
    output logic [DATA_W-1:0] masked
);

    always_comb begin
        store  = 1'b0;
        masked = '0;
        if (alt_bank) begin
            unique case (reg_num)
                RN_IDENT, RN_CACHEOP, RN_TLBOP, RN_TLBLCK: store = 1'b0;
                RN_CTRL:  begin store = 1'b1; masked = wdata & AUX_KEEP;   end
                RN_DLOCK: begin store = 1'b1; masked = wdata & DLOCK_KEEP; end
                default:  begin store = 1'b1; masked = wdata;              end
            endcase
        end else begin
            unique case (reg_num)
                RN_CTRL:   begin store = 1'b1; masked = (wdata & CTRL_KEEP) | CTRL_SET; end
                RN_XLAT:   begin store = 1'b1; masked = wdata & XLAT_KEEP;  end
                RN_DOMAIN: begin store = 1'b1; masked = wdata;              end
                RN_FSTAT:  begin store = 1'b1; masked = wdata & FSTAT_KEEP; end
                RN_FADDR:  begin store = 1'b1; masked = wdata;              end
                RN_DLOCK:  begin store = 1'b1; masked = wdata & DLOCK_KEEP; end
                RN_PID:    begin store = 1'b1; masked = wdata & PID_KEEP;   end
                RN_CPACC:  begin store = 1'b1; masked = wdata & CPACC_KEEP; end
                default:   store = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [OP_W-1:0]   req_op1,
    input  logic [OP_W-1:0]   req_op2,
    input  logic [CRM_W-1:0]  req_crm,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_refused,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              endian_pulse,
    output logic              endian_level
);

    logic [DATA_W-1:0] bank_pri_q [NUM_REGS];
    logic [DATA_W-1:0] bank_alt_q [NUM_REGS];
    logic [DATA_W-1:0] bp_q       [NUM_BP];

    rsp_state_t        state_q, state_d;
    logic [DATA_W-1:0] rd_q;
    logic              pulse_q;

    logic              legal;
    logic              alt_bank;
    logic              store;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] rd_val;
    logic              wr_fire;
    logic              rd_fire;
    logic              bp_fire;
    logic [BP_IDX_W-1:0] slot;

    sysctl_legal u_legal (
        .user_mode (req_user),
        .reg_num   (req_reg),
        .op1       (req_op1),
        .op2       (req_op2),
        .crm       (req_crm),
        .legal     (legal)
    );

    assign alt_bank = (req_op2 != '0);

    sysctl_wmask u_wmask (
        .reg_num  (req_reg),
        .alt_bank (alt_bank),
        .wdata    (req_wdata),
        .store    (store),
        .masked   (masked)
    );

    assign wr_fire = req_valid && req_write && legal;
    assign rd_fire = req_valid && !req_write && legal;
    assign bp_fire = wr_fire && (req_reg == RN_BRKPT);
    assign slot    = bp_slot(req_crm);

    // Read selection: breakpoint words by auxiliary field, operation registers zero.
    always_comb begin
        if (req_reg == RN_BRKPT) begin
            rd_val = bp_q[slot];
        end else if ((req_reg == RN_CACHEOP) || (req_reg == RN_TLBOP) ||
                     (req_reg == RN_TLBLCK)) begin
            rd_val = '0;
        end else if (alt_bank) begin
            rd_val = bank_alt_q[req_reg];
        end else begin
            rd_val = bank_pri_q[req_reg];
        end
    end

    // Bank storage, one generate branch per word so each carries its own reset value.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_bank
        localparam logic [DATA_W-1:0] PRI_RST =
            (gi == 0) ? RST_IDENT : ((gi == 1) ? RST_CTRL : '0);
        localparam logic [DATA_W-1:0] ALT_RST = (gi == 0) ? RST_CTYPE : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_pri_q[gi] <= PRI_RST;
            end else if (wr_fire && store && !alt_bank && (req_reg == REG_W'(gi))) begin
                bank_pri_q[gi] <= masked;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_alt_q[gi] <= ALT_RST;
            end else if (wr_fire && store && alt_bank && (req_reg == REG_W'(gi))) begin
                bank_alt_q[gi] <= masked;
            end
        end
    end

    for (genvar gb = 0; gb < NUM_BP; gb++) begin : g_bp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bp_q[gb] <= '0;
            end else if (bp_fire && (slot == BP_IDX_W'(gb))) begin
                bp_q[gb] <= req_wdata;
            end
        end
    end

    // Next response state.
    always_comb begin
        state_d = RSP_IDLE;
        if (req_valid) begin
            if (!legal)         state_d = RSP_REFUSE;
            else if (req_write) state_d = RSP_WRITE;
            else                state_d = RSP_READ;
        end
    end

    // State register with the read data and byte-order pulse captured alongside.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rd_q    <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_fire ? rd_val : '0;
            pulse_q <= wr_fire && !alt_bank && (req_reg == RN_CTRL) &&
                       (masked[CTRL_ENDIAN_BIT] != bank_pri_q[RN_CTRL][CTRL_ENDIAN_BIT]);
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_refused = 1'b0;
        rsp_rdata   = '0;
        unique case (state_q)
            RSP_IDLE:   ;
            RSP_READ:   begin rsp_valid = 1'b1; rsp_rdata = rd_q; end
            RSP_WRITE:  rsp_valid = 1'b1;
            RSP_REFUSE: begin rsp_valid = 1'b1; rsp_refused = 1'b1; end
        endcase
    end

    assign endian_pulse = pulse_q;
    assign endian_level = bank_pri_q[RN_CTRL][CTRL_ENDIAN_BIT];

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_user,
    input logic [REG_W-1:0]  req_reg,
    input logic [OP_W-1:0]   req_op1,
    input logic [OP_W-1:0]   req_op2,
    input logic [CRM_W-1:0]  req_crm,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_refused,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              endian_pulse,
    input logic              endian_level
);

    // R1
    assert_user_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user) |=> (rsp_valid && rsp_refused));

    // R2
    assert_op1_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op1 != '0)) |=> (rsp_valid && rsp_refused));

    // R3
    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_refused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_refused |-> (rsp_valid && (rsp_rdata == '0)));

    // R8
    assert_pulse_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        endian_pulse |-> (endian_level != $past(endian_level)));

    assert_level_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !endian_pulse |-> $stable(endian_level));

endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (.*);

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/100ps
module sysctl_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [3:0]  req_reg = '0;
    logic [2:0]  req_op1 = '0;
    logic [2:0]  req_op2 = '0;
    logic [3:0]  req_crm = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_refused;
    logic [31:0] rsp_rdata;
    logic        endian_pulse;
    logic        endian_level;

    int checks = 0;
    int failures = 0;
    logic        s_ref;
    logic [31:0] s_data;
    logic        s_valid;
    logic        s_pulse;

    always #2.5 clk = ~clk;

    sysctl_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_reg(req_reg), .req_op1(req_op1), .req_op2(req_op2),
        .req_crm(req_crm), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_refused(rsp_refused), .rsp_rdata(rsp_rdata),
        .endian_pulse(endian_pulse), .endian_level(endian_level)
    );

    // Vector: {req_tag[3:0], wr, user, reg[3:0], op1[2:0], op2[2:0], crm[3:0], wdata, exp_ref, exp_data}
    function automatic logic [84:0] mk(input logic [3:0] tag, input logic wr, input logic usr,
                                       input logic [3:0] r, input logic [2:0] o1,
                                       input logic [2:0] o2, input logic [3:0] c,
                                       input logic [31:0] wd, input logic er,
                                       input logic [31:0] ed);
        mk = {tag, wr, usr, r, o1, o2, c, wd, er, ed};
    endfunction

    localparam int NV = 54;
    localparam logic [84:0] VEC [NV] = '{
        mk(4, 0,0, 0,0,0,0, 32'h0,        0, 32'h6905_2000), // R4
        mk(4, 0,0, 0,0,1,0, 32'h0,        0, 32'h0B1A_A1AA), // R4
        mk(4, 0,0, 1,0,0,0, 32'h0,        0, 32'h0000_0078), // R4
        mk(5, 0,0, 1,0,1,0, 32'h0,        0, 32'h0),         // R5
        mk(6, 1,0, 0,0,0,0, 32'hFFFF_FFFF,0, 32'h0),         // R6
        mk(6, 0,0, 0,0,0,0, 32'h0,        0, 32'h6905_2000), // R6
        mk(6, 1,0, 0,0,1,0, 32'hFFFF_FFFF,0, 32'h0),         // R6
        mk(6, 0,0, 0,0,1,0, 32'h0,        0, 32'h0B1A_A1AA), // R6
        mk(7, 1,0, 1,0,0,0, 32'hFFFF_FFFF,0, 32'h0),         // R7
        mk(7, 0,0, 1,0,0,0, 32'h0,        0, 32'h0000_3BFF), // R7
        mk(9, 1,0, 1,0,1,0, 32'hFFFF_FFFF,0, 32'h0),         // R9
        mk(9, 0,0, 1,0,1,0, 32'h0,        0, 32'h0000_0033), // R9
        mk(5, 0,0, 1,0,0,0, 32'h0,        0, 32'h0000_3BFF), // R5
        mk(9, 1,0, 2,0,0,0, 32'hFFFF_FFFF,0, 32'h0),         // R9
        mk(9, 0,0, 2,0,0,0, 32'h0,        0, 32'hFFFF_C000), // R9
        mk(12,1,0, 2,0,0,1, 32'h0,        1, 32'h0),         // R12
        mk(3, 0,0, 2,0,0,0, 32'h0,        0, 32'hFFFF_C000), // R3
        mk(9, 1,0, 5,0,0,0, 32'hFFFF_FFFF,0, 32'h0),         // R9
        mk(9, 0,0, 5,0,0,0, 32'h0,        0, 32'h0000_06FF), // R9
        mk(9, 1,0,13,0,0,0, 32'hFFFF_FFFF,0, 32'h0),         // R9
        mk(9, 0,0,13,0,0,0, 32'h0,        0, 32'hFE00_0000), // R9
        mk(9, 1,0, 9,0,1,0, 32'hFFFF_FFFF,0, 32'h0),         // R9
        mk(9, 0,0, 9,0,1,0, 32'h0,        0, 32'h0000_0001), // R9
        mk(13,0,0, 9,0,0,0, 32'h0,        1, 32'h0),         // R13
        mk(10,1,0,15,0,0,1, 32'hFFFF_FFFF,0, 32'h0),         // R10
        mk(10,0,0,15,0,0,1, 32'h0,        0, 32'h0000_3FFF), // R10
        mk(10,0,0,15,0,0,0, 32'h0,        1, 32'h0),         // R10
        mk(11,1,0,14,0,0,3, 32'hA5A5_A5A5,0, 32'h0),         // R11
        mk(11,0,0,14,0,0,3, 32'h0,        0, 32'hA5A5_A5A5), // R11
        mk(11,0,0,14,0,0,0, 32'h0,        0, 32'h0),         // R11
        mk(11,1,0,14,0,0,9, 32'h5A5A_0000,0, 32'h0),         // R11
        mk(11,0,0,14,0,0,9, 32'h0,        0, 32'h5A5A_0000), // R11
        mk(11,0,0,14,0,0,5, 32'h0,        1, 32'h0),         // R11
        mk(11,0,0,14,0,1,0, 32'h0,        1, 32'h0),         // R11
        mk(12,0,0, 4,0,0,0, 32'h0,        1, 32'h0),         // R12
        mk(12,0,0,11,0,0,0, 32'h0,        1, 32'h0),         // R12
        mk(1, 0,1, 0,0,0,0, 32'h0,        1, 32'h0),         // R1
        mk(1, 1,1, 3,0,0,0, 32'hDEAD_BEEF,1, 32'h0),         // R1
        mk(1, 0,0, 3,0,0,0, 32'h0,        0, 32'h0),         // R1
        mk(2, 0,0, 0,1,0,0, 32'h0,        1, 32'h0),         // R2
        mk(13,1,0, 7,0,0,5, 32'hFFFF_FFFF,0, 32'h0),         // R13
        mk(13,0,0, 7,0,0,5, 32'h0,        0, 32'h0),         // R13
        mk(13,0,0, 7,0,2,5, 32'h0,        1, 32'h0),         // R13
        mk(12,1,0, 3,0,0,0, 32'hDEAD_BEEF,0, 32'h0),         // R12
        mk(12,0,0, 3,0,0,0, 32'h0,        0, 32'hDEAD_BEEF), // R12
        mk(12,0,0, 3,0,1,0, 32'h0,        1, 32'h0),         // R12
        mk(12,1,0, 6,0,0,0, 32'h1234_5678,0, 32'h0),         // R12
        mk(12,0,0, 6,0,0,0, 32'h0,        0, 32'h1234_5678), // R12
        mk(13,1,0,10,0,4,1, 32'hFFFF_FFFF,0, 32'h0),         // R13
        mk(13,0,0,10,0,4,0, 32'h0,        0, 32'h0),         // R13
        mk(13,0,0, 8,0,1,7, 32'h0,        1, 32'h0),         // R13
        mk(13,0,0, 8,0,0,7, 32'h0,        0, 32'h0),         // R13
        mk(2, 1,0, 6,2,0,0, 32'h0,        1, 32'h0),         // R2
        mk(2, 0,0, 6,0,0,0, 32'h0,        0, 32'h1234_5678)  // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one request at a falling edge; samples its response one cycle later.
    task automatic access(input logic wr, input logic usr, input logic [3:0] r,
                          input logic [2:0] o1, input logic [2:0] o2, input logic [3:0] c,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_user = usr; req_reg = r;
        req_op1 = o1; req_op2 = o2; req_crm = c; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
        s_valid = rsp_valid; s_ref = rsp_refused; s_data = rsp_rdata; s_pulse = endian_pulse;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state at the ports
        check("R4 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check("R4 endian_level", {31'b0, endian_level}, 32'h0);
        check("R4 endian_pulse", {31'b0, endian_pulse}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            string tg;
            v = VEC[i];
            tg = $sformatf("R%0d vec%0d", v[84:81], i);
            access(v[80], v[79], v[78:75], v[74:72], v[71:69], v[68:65], v[64:33]);
            check({tg, " valid"}, {31'b0, s_valid}, 32'h1);
            check({tg, " refused"}, {31'b0, s_ref}, {31'b0, v[32]});
            check({tg, " rdata"}, s_data, v[31:0]);
        end

        // R3: no request, no response
        @(negedge clk);
        check("R3 idle valid", {31'b0, rsp_valid}, 32'h0);

        // R8: control word is 0x3BFF here, so byte order is 1
        check("R8 level before", {31'b0, endian_level}, 32'h1);
        access(1, 0, 1, 0, 0, 0, 32'h0);
        check("R8 pulse on 1->0", {31'b0, s_pulse}, 32'h1);
        check("R8 level after 1->0", {31'b0, endian_level}, 32'h0);
        access(1, 0, 1, 0, 0, 0, 32'h0);
        check("R8 no pulse same", {31'b0, s_pulse}, 32'h0);
        access(1, 0, 1, 0, 0, 0, 32'h0000_0080);
        check("R8 pulse on 0->1", {31'b0, s_pulse}, 32'h1);
        check("R8 level after 0->1", {31'b0, endian_level}, 32'h1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'b0, endian_pulse}, 32'h0);
        access(0, 0, 1, 0, 0, 0, 32'h0);
        check("R7 ctrl readback", s_data, 32'h0000_00F8);

        // R1: refused user write to the control word leaves byte order alone
        access(1, 1, 1, 0, 0, 0, 32'h0);
        check("R1 no pulse", {31'b0, s_pulse}, 32'h0);
        check("R1 level kept", {31'b0, endian_level}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule